// File: doc/BRIEF.md
# Static Virtual-Link Frame Forwarder

The block decides, for every frame entering a switch port, which egress ports receive a copy. The only key is the virtual-link identifier that upstream parsing pulls out of the frame header. A one-way link from one source goes to one destination (one bit set in the port mask) or to several (multicast, several bits set). The routing table is loaded through a configuration write port while the system is being set up. A lock input then freezes it. Nothing is learned from traffic.

An upstream parser pulses `sof_stb` with the identifier. Two clocks later the block does one of two things. It raises `fwd_vld` for one cycle together with the egress bitmask. Otherwise it raises `drop_pulse` and increments a saturating drop counter. A frame is dropped when its identifier is unknown, outside the table, or mapped to an empty mask. Egress scheduling downstream takes the mask as it is. The mask is never edited, for example to remove the arrival port.

The control path is a three-state machine:
- `ST_IDLE`: no lookup in progress.
- `ST_READ`: the table entry is being fetched.
- `ST_DECIDE`: the result is presented.

Its transitions are:
- IDLE→READ when a strobe is accepted.
- READ→DECIDE unconditionally.
- DECIDE→READ when a new strobe is accepted.
- DECIDE→IDLE when no strobe arrives.

Top module: `vlink_fwd`

## Requirements
- R1: After reset, `fwd_vld`, `fwd_mask`, `drop_pulse`, `cfg_rej` and `drop_cnt` are zero, and every table entry is invalid, so any lookup is dropped.
- R2: A strobe with an identifier whose entry is enabled and has a nonzero mask produces `fwd_vld` high for exactly one cycle, two clocks after the strobe edge. `fwd_mask` then equals the stored mask bit for bit. Bit i of the mask selects egress port i.
- R3: A strobe whose entry is disabled, or whose stored mask is all zero, produces `drop_pulse` for one cycle in the same slot instead of `fwd_vld`. `drop_cnt` rises by one in that same cycle.
- R4: Identifiers at or above DEPTH (4096 by default) always drop, even when their low bits index an enabled entry. Identifier DEPTH-1 is a usable entry.
- R5: `drop_cnt` stops at its all-ones value and does not wrap.
- R6: A write with `cfg_we` high stores the mask and enable bit only while `cfg_lock` is low and `cfg_addr` is below DEPTH. In any other case the table is unchanged, and `cfg_rej` is high in the cycle after the attempt.
- R7: A strobe in the cycle directly after an accepted strobe is ignored and yields no result. Strobes two cycles apart each yield a result. `fwd_vld` is never high in two consecutive cycles.
- R8: A write and a lookup of the same entry in the same cycle return the entry's old contents. Later lookups see the new contents.
- R9: `fwd_mask` is zero whenever `fwd_vld` is low, and `fwd_vld` and `drop_pulse` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof_stb | input | 1 | Frame-start strobe, identifier valid |
| sof_vlid | input | ID_W | Virtual-link identifier of the frame |
| cfg_we | input | 1 | Table write request |
| cfg_lock | input | 1 | High freezes the table |
| cfg_addr | input | ID_W | Identifier whose entry is written |
| cfg_mask | input | PORTS | Egress port mask to store |
| cfg_en | input | 1 | Enable bit to store with the mask |
| fwd_vld | output | 1 | Forward decision valid |
| fwd_mask | output | PORTS | Egress port bitmask |
| drop_pulse | output | 1 | Frame dropped this cycle |
| drop_cnt | output | CNT_W | Saturating count of dropped frames |
| cfg_rej | output | 1 | Previous cycle's write was refused |

## Verification
A table write and a lookup can hit the same entry in one cycle. The bench provokes this by raising `cfg_we` and `sof_stb` on the same falling edge with equal identifier and address. It expects the lookup to report the entry's previous state (a drop for a fresh entry), and the next lookup to forward the newly written mask. A second coincidence also arises: a strobe landing while a lookup is still in its fetch cycle. The bench drives strobes one cycle apart and expects the second to be ignored. It then drives strobes two cycles apart and expects both to be answered.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_DECIDE = 2'd2
    } vlf_state_e;

endpackage

// File: rtl/vlf_table.sv
module vlf_table #(
    parameter int ID_W  = 16,
    parameter int DEPTH = 4096,
    parameter int PORTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_lock,
    input  logic [ID_W-1:0]  wr_addr,
    input  logic [PORTS-1:0] wr_mask,
    input  logic             wr_valid,
    input  logic             rd_stb,
    input  logic [ID_W-1:0]  rd_addr,
    output logic [PORTS-1:0] rd_mask,
    output logic             rd_valid,
    output logic             wr_rej
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [PORTS-1:0] mask_mem [DEPTH];
    logic [DEPTH-1:0] en_bits;

    logic             wr_in_rng;
    logic             rd_in_rng;
    logic             wr_ok;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign wr_in_rng = 32'(wr_addr) < DEPTH;
    assign rd_in_rng = 32'(rd_addr) < DEPTH;
    assign wr_ok     = wr_en && !wr_lock && wr_in_rng;
    assign wr_idx    = wr_addr[IDX_W-1:0];
    assign rd_idx    = rd_addr[IDX_W-1:0];

    // mask storage carries no reset; the enable bits gate it
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mask_mem[wr_idx] <= wr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_bits <= '0;
        end else if (wr_ok) begin
            en_bits[wr_idx] <= wr_valid;
        end
    end

    // read-before-write: nonblocking update leaves the old entry visible
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_mask  <= '0;
            rd_valid <= 1'b0;
        end else if (rd_stb) begin
            rd_mask  <= mask_mem[rd_idx];
            rd_valid <= en_bits[rd_idx] && rd_in_rng;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_rej <= 1'b0;
        end else begin
            wr_rej <= wr_en && (wr_lock || !wr_in_rng);
        end
    end

endmodule

// File: rtl/vlf_ctrl.sv
module vlf_ctrl
    import vlf_pkg::*;
#(
    parameter int PORTS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_stb,
    input  logic             rd_valid,
    input  logic [PORTS-1:0] rd_mask,
    output logic             rd_stb,
    output logic             drop_evt,
    output logic             fwd_vld,
    output logic [PORTS-1:0] fwd_mask,
    output logic             drop_pulse
);

    vlf_state_e state_q;
    vlf_state_e state_d;
    logic       hit;

    assign rd_stb   = sof_stb && (state_q != ST_READ);
    assign hit      = rd_valid && (|rd_mask);
    assign drop_evt = (state_q == ST_READ) && !hit;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = rd_stb ? ST_READ : ST_IDLE;
            ST_READ:   state_d = ST_DECIDE;
            ST_DECIDE: state_d = rd_stb ? ST_READ : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_vld    <= 1'b0;
            fwd_mask   <= '0;
            drop_pulse <= 1'b0;
        end else begin
            fwd_vld    <= (state_q == ST_READ) && hit;
            fwd_mask   <= ((state_q == ST_READ) && hit) ? rd_mask : '0;
            drop_pulse <= drop_evt;
        end
    end

endmodule

// File: rtl/vlf_drop_cnt.sv
module vlf_drop_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != '1)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/vlink_fwd.sv
module vlink_fwd #(
    parameter int ID_W  = 16,
    parameter int DEPTH = 4096,
    parameter int PORTS = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sof_stb,
    input  logic [ID_W-1:0]  sof_vlid,
    input  logic             cfg_we,
    input  logic             cfg_lock,
    input  logic [ID_W-1:0]  cfg_addr,
    input  logic [PORTS-1:0] cfg_mask,
    input  logic             cfg_en,
    output logic             fwd_vld,
    output logic [PORTS-1:0] fwd_mask,
    output logic             drop_pulse,
    output logic [CNT_W-1:0] drop_cnt,
    output logic             cfg_rej
);

    logic             rd_stb;
    logic             rd_valid;
    logic [PORTS-1:0] rd_mask;
    logic             drop_evt;

    vlf_table #(
        .ID_W  (ID_W),
        .DEPTH (DEPTH),
        .PORTS (PORTS)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_lock  (cfg_lock),
        .wr_addr  (cfg_addr),
        .wr_mask  (cfg_mask),
        .wr_valid (cfg_en),
        .rd_stb   (rd_stb),
        .rd_addr  (sof_vlid),
        .rd_mask  (rd_mask),
        .rd_valid (rd_valid),
        .wr_rej   (cfg_rej)
    );

    vlf_ctrl #(
        .PORTS (PORTS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sof_stb    (sof_stb),
        .rd_valid   (rd_valid),
        .rd_mask    (rd_mask),
        .rd_stb     (rd_stb),
        .drop_evt   (drop_evt),
        .fwd_vld    (fwd_vld),
        .fwd_mask   (fwd_mask),
        .drop_pulse (drop_pulse)
    );

    vlf_drop_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (drop_evt),
        .count (drop_cnt)
    );

endmodule

// File: rtl/vlf_chk.sv
module vlf_chk #(
    parameter int PORTS = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sof_stb,
    input logic             cfg_we,
    input logic             cfg_lock,
    input logic             fwd_vld,
    input logic [PORTS-1:0] fwd_mask,
    input logic             drop_pulse,
    input logic [CNT_W-1:0] drop_cnt,
    input logic             cfg_rej
);

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_vld || drop_pulse) |-> $past(sof_stb, 2)); // R2

    AST_FWD_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld |-> (fwd_mask != '0)); // R2

    AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> ((drop_cnt == CNT_W'($past(drop_cnt) + 1'b1))
                        || (($past(drop_cnt) == '1) && (drop_cnt == '1)))); // R3

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !drop_pulse |-> $stable(drop_cnt)); // R5

    AST_LOCK_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_lock) |=> cfg_rej); // R6

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_vld |=> !fwd_vld); // R7

    AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_vld |-> (fwd_mask == '0)); // R9

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_vld && drop_pulse)); // R9

endmodule

bind vlink_fwd vlf_chk #(.PORTS(PORTS), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_vlink_fwd.sv
`timescale 1ns/1ps
module sim_vlink_fwd;

    localparam int ID_W  = 16;
    localparam int DEPTH = 4096;
    localparam int PORTS = 8;
    localparam int CNT_W = 4;

    typedef struct {
        bit               is_fwd;
        logic [PORTS-1:0] mask;
        int               due;
        string            req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sof_stb = 1'b0;
    logic [ID_W-1:0]  sof_vlid = '0;
    logic             cfg_we = 1'b0;
    logic             cfg_lock = 1'b0;
    logic [ID_W-1:0]  cfg_addr = '0;
    logic [PORTS-1:0] cfg_mask = '0;
    logic             cfg_en = 1'b0;
    logic             fwd_vld;
    logic [PORTS-1:0] fwd_mask;
    logic             drop_pulse;
    logic [CNT_W-1:0] drop_cnt;
    logic             cfg_rej;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   exp_drops = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vlink_fwd #(.ID_W(ID_W), .DEPTH(DEPTH), .PORTS(PORTS), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .sof_stb(sof_stb), .sof_vlid(sof_vlid),
        .cfg_we(cfg_we), .cfg_lock(cfg_lock), .cfg_addr(cfg_addr),
        .cfg_mask(cfg_mask), .cfg_en(cfg_en), .fwd_vld(fwd_vld),
        .fwd_mask(fwd_mask), .drop_pulse(drop_pulse), .drop_cnt(drop_cnt),
        .cfg_rej(cfg_rej)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when an item falls due
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t it;
                it = sb.pop_front();
                if (it.is_fwd) begin
                    check(fwd_vld && !drop_pulse && fwd_mask == it.mask, it.req,
                          "forward mask", fwd_vld ? int'(fwd_mask) : -1, int'(it.mask));
                end else begin
                    check(drop_pulse && !fwd_vld && fwd_mask == '0, it.req,
                          "drop pulse", {drop_pulse, fwd_vld}, 2);
                    if (exp_drops < (1 << CNT_W) - 1) exp_drops++;
                    check(int'(drop_cnt) == exp_drops,
                          (exp_drops == (1 << CNT_W) - 1) ? "R5" : "R3",
                          "drop count", int'(drop_cnt), exp_drops);
                end
            end else if (fwd_vld || drop_pulse) begin
                check(1'b0, "R7", "unexpected result", {fwd_vld, drop_pulse}, 0);
            end
        end
    end

    task automatic lookup(input logic [ID_W-1:0] id, input bit is_fwd,
                          input logic [PORTS-1:0] m, input string req);
        exp_t it;
        it.is_fwd = is_fwd; it.mask = m; it.due = cyc + 2; it.req = req;
        sb.push_back(it);
        sof_stb = 1'b1; sof_vlid = id;
        @(negedge clk);
        sof_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [ID_W-1:0] a, input logic [PORTS-1:0] m,
                             input bit en, input bit exp_rej, input string req);
        cfg_we = 1'b1; cfg_addr = a; cfg_mask = m; cfg_en = en;
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_rej == exp_rej, req, "write reject flag", int'(cfg_rej), int'(exp_rej));
    endtask

    task automatic push_only(input logic [ID_W-1:0] id, input bit is_fwd,
                             input logic [PORTS-1:0] m, input string req);
        exp_t it;
        it.is_fwd = is_fwd; it.mask = m; it.due = cyc + 2; it.req = req;
        sb.push_back(it);
        sof_stb = 1'b1; sof_vlid = id;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!fwd_vld && fwd_mask == '0 && !drop_pulse && !cfg_rej, "R1",
              "outputs after reset", {fwd_vld, drop_pulse, cfg_rej}, 0);
        check(drop_cnt == '0, "R1", "drop count after reset", int'(drop_cnt), 0);
        lookup(16'd5, 1'b0, '0, "R1");

        // table load
        cfg_write(16'd3,    8'h04, 1'b1, 1'b0, "R6");
        cfg_write(16'd10,   8'hA5, 1'b1, 1'b0, "R6");
        cfg_write(16'd20,   8'h00, 1'b1, 1'b0, "R6");
        cfg_write(16'd30,   8'hFF, 1'b0, 1'b0, "R6");
        cfg_write(16'd4095, 8'h81, 1'b1, 1'b0, "R6");

        lookup(16'd3,    1'b1, 8'h04, "R2");
        lookup(16'd10,   1'b1, 8'hA5, "R2");
        lookup(16'd20,   1'b0, '0,    "R3");
        lookup(16'd30,   1'b0, '0,    "R3");
        lookup(16'd4095, 1'b1, 8'h81, "R4");
        lookup(16'd4096, 1'b0, '0,    "R4");
        lookup(16'hF003, 1'b0, '0,    "R4");

        // R6 lock and range gating
        cfg_lock = 1'b1;
        cfg_write(16'd3, 8'h10, 1'b1, 1'b1, "R6");
        lookup(16'd3, 1'b1, 8'h04, "R6");
        cfg_lock = 1'b0;
        cfg_write(16'd5000, 8'h11, 1'b1, 1'b1, "R6");
        lookup(16'd5000, 1'b0, '0, "R6");
        cfg_write(16'd3, 8'h30, 1'b1, 1'b0, "R6");
        lookup(16'd3, 1'b1, 8'h30, "R6");

        // R7 strobe during fetch ignored, then spacing of two
        push_only(16'd10, 1'b1, 8'hA5, "R7");
        @(negedge clk);
        sof_vlid = 16'd3;
        @(negedge clk);
        sof_stb = 1'b0;
        repeat (3) @(negedge clk);
        push_only(16'd10, 1'b1, 8'hA5, "R7");
        @(negedge clk);
        sof_stb = 1'b0;
        @(negedge clk);
        push_only(16'd3, 1'b1, 8'h30, "R7");
        @(negedge clk);
        sof_stb = 1'b0;
        repeat (3) @(negedge clk);

        // R8 write and lookup of one entry in one cycle
        cfg_we = 1'b1; cfg_addr = 16'd40; cfg_mask = 8'h22; cfg_en = 1'b1;
        push_only(16'd40, 1'b0, '0, "R8");
        @(negedge clk);
        cfg_we = 1'b0; sof_stb = 1'b0;
        @(negedge clk);
        lookup(16'd40, 1'b1, 8'h22, "R8");

        // R5 saturation of the drop counter
        for (int i = 0; i < 20; i++) lookup(16'd5, 1'b0, '0, "R5");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", "results outstanding", sb.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule